// File: doc/BRIEF.md
# Hierarchical 4x4 Unsigned Array Multiplier

This block multiplies two unsigned 4-bit operands and returns their full 8-bit product. It is purely combinational: there is no clock, no reset and no state, so the product follows the operands after the longest carry path through the adder network has settled.

The product is built in layers. A half adder and a full adder are the only arithmetic primitives. The full adder is made from two half adders and an OR gate. A 2x2 multiplier cell combines four AND-gate partial products with two half adders. Each operand is split into a low and a high 2-bit digit. Four 2x2 cells form the four digit-by-digit sub-products. Two ripple adders made only of the adder cells then merge those sub-products at their proper bit offsets.

Top module: `mul4x4_array`

## Requirements
- R1: For every pair of 4-bit operands, `product` equals the unsigned arithmetic product of `opA` and `opB`.
- R2: Each 2x2 cell returns the 4-bit product of its two 2-bit digits for all 16 digit pairs. The low-by-low cell appears at bit offset 0 of `product`. The two mixed cells appear at offset 2, and the high-by-high cell appears at offset 4.
- R3: The full adder's sum output is 1 exactly for input codes {x,y,cin} = 1, 2, 4 and 7. Its carry output is 1 exactly for codes 3, 5, 6 and 7.
- R4: The half adder's sum output is x xor y, and its carry output is x and y.
- R5: Bit 0 of `product` equals `opA[0] & opB[0]` for every operand pair.
- R6: `product` never exceeds 225 (15 x 15). The carry out of the top column is therefore never needed.
- R7: If either operand is zero, `product` is zero.
- R8: Swapping `opA` and `opB` leaves `product` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 4 | Unsigned multiplier operand |
| opB | input | 4 | Unsigned multiplicand operand |
| product | output | 8 | Unsigned product opA x opB |

## Verification
The bench builds the block only with its fixed 4-bit operand and 2-bit digit widths. Because these widths are fixed, the whole input space of 256 operand pairs can be driven, and every pair is checked against an independent A*B model.

Operands that are non-zero in only one digit of each operand place a single 2x2 cell alone on the output. This lets each cell be swept over all 16 digit pairs. Standalone half-adder and full-adder instances are walked through their full truth tables.

// File: rtl/mul_pkg.sv
package mul_pkg;
  localparam int OPER_W    = 4;
  localparam int DIGIT_W   = 2;
  localparam int PROD_W    = 2 * OPER_W;
  localparam int CELL_W    = 2 * DIGIT_W;
  localparam int NUM_CELLS = (OPER_W / DIGIT_W) * (OPER_W / DIGIT_W);
  localparam int MID_W     = CELL_W + 1;
  localparam int TOP_W     = PROD_W - DIGIT_W;

  typedef logic [DIGIT_W-1:0] digit_t;
  typedef logic [CELL_W-1:0]  cellProd_t;
endpackage

// File: rtl/mul_half_add.sv
module mul_half_add (
  input  logic x,
  input  logic y,
  output logic sum,
  output logic carry
);
  assign sum   = x ^ y;
  assign carry = x & y;
endmodule

// File: rtl/mul_full_add.sv
module mul_full_add (
  input  logic x,
  input  logic y,
  input  logic cin,
  output logic sum,
  output logic cout
);
  logic partSum;
  logic carryA;
  logic carryB;

  mul_half_add u_haLow (.x(x),       .y(y),   .sum(partSum), .carry(carryA));
  mul_half_add u_haHigh(.x(partSum), .y(cin), .sum(sum),     .carry(carryB));

  assign cout = carryA | carryB;
endmodule

// File: rtl/mul_ripple_add.sv
module mul_ripple_add #(
  parameter int W          = 4,
  parameter bit KEEP_CARRY = 1'b1
) (
  input  logic [W-1:0]            a,
  input  logic [W-1:0]            b,
  output logic [W+KEEP_CARRY-1:0] sum
);
  logic [W-2:0] carry;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      mul_half_add u_ha (.x(a[0]), .y(b[0]), .sum(sum[0]), .carry(carry[0]));
    end else if (i == W - 1) begin : g_msb
      if (KEEP_CARRY) begin : g_keep
        mul_full_add u_fa (.x(a[i]), .y(b[i]), .cin(carry[i-1]),
                           .sum(sum[i]), .cout(sum[W+KEEP_CARRY-1]));
      end else begin : g_drop
        assign sum[i] = a[i] ^ b[i] ^ carry[i-1];
      end
    end else begin : g_mid
      mul_full_add u_fa (.x(a[i]), .y(b[i]), .cin(carry[i-1]),
                         .sum(sum[i]), .cout(carry[i]));
    end
  end
endmodule

// File: rtl/mul_cell2x2.sv
module mul_cell2x2
  import mul_pkg::*;
(
  input  digit_t    digA,
  input  digit_t    digB,
  output cellProd_t cellProd
);
  logic pp00, pp10, pp01, pp11;
  logic midCarry;

  assign pp00 = digA[0] & digB[0];
  assign pp10 = digA[1] & digB[0];
  assign pp01 = digA[0] & digB[1];
  assign pp11 = digA[1] & digB[1];

  assign cellProd[0] = pp00;

  mul_half_add u_haMid (.x(pp10), .y(pp01),     .sum(cellProd[1]), .carry(midCarry));
  mul_half_add u_haTop (.x(pp11), .y(midCarry), .sum(cellProd[2]), .carry(cellProd[3]));
endmodule

// File: rtl/mul4x4_array.sv
module mul4x4_array
  import mul_pkg::*;
(
  input  logic [OPER_W-1:0] opA,
  input  logic [OPER_W-1:0] opB,
  output logic [PROD_W-1:0] product
);
  // cell k: bit 0 picks the opA digit, bit 1 picks the opB digit
  cellProd_t subProd [NUM_CELLS];
  logic [MID_W-1:0] midSum;
  logic [TOP_W-1:0] topSum;

  for (genvar k = 0; k < NUM_CELLS; k++) begin : g_cell
    localparam int A_OFF = (k % 2) * DIGIT_W;
    localparam int B_OFF = (k / 2) * DIGIT_W;
    mul_cell2x2 u_cell (
      .digA    (opA[A_OFF +: DIGIT_W]),
      .digB    (opB[B_OFF +: DIGIT_W]),
      .cellProd(subProd[k])
    );
  end

  // both mixed sub-products share offset DIGIT_W
  mul_ripple_add #(.W(CELL_W), .KEEP_CARRY(1'b1)) u_midAdd (
    .a  (subProd[1]),
    .b  (subProd[2]),
    .sum(midSum)
  );

  // high-by-high and upper half of low-by-low do not overlap: merge by concatenation
  mul_ripple_add #(.W(TOP_W), .KEEP_CARRY(1'b0)) u_topAdd (
    .a  ({{(TOP_W-MID_W){1'b0}}, midSum}),
    .b  ({subProd[3], subProd[0][CELL_W-1:DIGIT_W]}),
    .sum(topSum)
  );

  assign product = {topSum, subProd[0][DIGIT_W-1:0]};
endmodule

// File: rtl/mul4x4_array_checker.sv
module mul4x4_array_checker
  import mul_pkg::*;
(
  input logic [OPER_W-1:0] opA,
  input logic [OPER_W-1:0] opB,
  input logic [PROD_W-1:0] product
);
  always_comb begin
    AST_PRODUCT_MATCH: assert (product == PROD_W'(opA) * PROD_W'(opB)); // R1
    AST_LSB_AND:       assert (product[0] == (opA[0] & opB[0]));       // R5
    AST_NO_OVERFLOW:   assert (product <= PROD_W'(225));               // R6
    if (opA == '0 || opB == '0)
      AST_ZERO_ABSORB: assert (product == '0);                         // R7
  end
endmodule

module mul_full_add_checker (
  input logic x,
  input logic y,
  input logic cin,
  input logic sum,
  input logic cout
);
  always_comb begin
    AST_FA_SUM_CODES:   assert (sum  == ($countones({x, y, cin}) % 2 == 1)); // R3
    AST_FA_CARRY_CODES: assert (cout == ($countones({x, y, cin}) >= 2));     // R3
  end
endmodule

bind mul4x4_array mul4x4_array_checker u_chk (.opA(opA), .opB(opB), .product(product));
bind mul_full_add mul_full_add_checker u_faChk (.x(x), .y(y), .cin(cin), .sum(sum), .cout(cout));

// File: tb/mul4x4_array_test.sv
module mul4x4_array_test;
  typedef struct {
    logic [3:0] a;
    logic [3:0] b;
    logic [7:0] expProd;
    string      req;
  } item_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] opA = '0;
  logic [3:0] opB = '0;
  logic [7:0] product;
  int         checks = 0;
  int         failures = 0;
  int         cycles = 0;
  bit         done = 1'b0;
  item_t      expQ[$];

  logic faX = 0, faY = 0, faC = 0, faS, faCo;
  logic haX = 0, haY = 0, haS, haC;

  always #2 clk = ~clk;

  mul4x4_array uut (.opA(opA), .opB(opB), .product(product));
  mul_full_add u_faRef (.x(faX), .y(faY), .cin(faC), .sum(faS), .cout(faCo));
  mul_half_add u_haRef (.x(haX), .y(haY), .sum(haS), .carry(haC));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] a, input logic [3:0] b, input string req);
    item_t it;
    @(posedge clk);
    opA = a;
    opB = b;
    it.a = a;
    it.b = b;
    it.expProd = 8'(int'(a) * int'(b));
    it.req = req;
    expQ.push_back(it);
  endtask

  // monitor: samples on the falling edge, half a period after each drive
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && expQ.size() > 0) begin
        item_t it;
        it = expQ.pop_front();
        check(product == it.expProd, it.req, product, it.expProd);
        if (it.req == "R1") begin
          check(product[0] == (it.a[0] & it.b[0]), "R5", product[0], it.a[0] & it.b[0]);
          check(product <= 8'd225, "R6", product, 225);
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000 && !done) begin
        check(1'b0, "WATCHDOG", cycles, 20000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] fwd;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(product == 8'd0, "R7", product, 0); // reset-state operands 0 x 0
    rstN = 1'b1;

    // R1: exhaustive sweep
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        drive(4'(i), 4'(j), "R1");

    // R2: each cell isolated by its digit position
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        drive(4'(i),      4'(j),      "R2");
        drive(4'(i << 2), 4'(j),      "R2");
        drive(4'(i),      4'(j << 2), "R2");
        drive(4'(i << 2), 4'(j << 2), "R2");
      end

    // R7: zero operand on either side
    for (int i = 0; i < 16; i++) begin
      drive(4'(i), 4'd0, "R7");
      drive(4'd0, 4'(i), "R7");
    end

    // R6: corner of the range
    drive(4'd15, 4'd15, "R6");
    repeat (3) @(posedge clk);

    // R8: operand swap
    for (int i = 0; i < 16; i++)
      for (int j = i + 1; j < 16; j += 3) begin
        @(posedge clk); opA = 4'(i); opB = 4'(j);
        @(negedge clk); fwd = product;
        @(posedge clk); opA = 4'(j); opB = 4'(i);
        @(negedge clk);
        check(product == fwd, "R8", product, fwd);
      end

    // R3: full adder truth table over codes {x,y,cin}
    for (int c = 0; c < 8; c++) begin
      {faX, faY, faC} = 3'(c);
      #1;
      check(faS  == (c == 1 || c == 2 || c == 4 || c == 7), "R3", faS,
            (c == 1 || c == 2 || c == 4 || c == 7));
      check(faCo == (c == 3 || c == 5 || c == 6 || c == 7), "R3", faCo,
            (c == 3 || c == 5 || c == 6 || c == 7));
    end

    // R4: half adder truth table
    for (int c = 0; c < 4; c++) begin
      {haX, haY} = 2'(c);
      #1;
      check(haS == (c == 1 || c == 2), "R4", haS, (c == 1 || c == 2));
      check(haC == (c == 3), "R4", haC, (c == 3));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule